// File: doc/BRIEF.md
# Serial Boot Loader Engine

This block lets an external host load a program into on-chip RAM over a byte-wide serial link, with no processor involved. The block sits between a UART core and a RAM write port. The UART core has already turned the line signal into bytes. The link runs at 115200 baud with 8 data bits, 1 stop bit and no parity. All of that framing belongs to the UART core.

The block starts the exchange by offering a start byte. It then collects a three-byte header from the host: a marker byte followed by a 16-bit length, low byte first. It answers the header with an accept or a reject byte. After an accept it stores the payload into RAM as little-endian 32-bit words, starting at a base address. It then returns an XOR checksum of the payload.

If the host's closing reply is the accept byte, the block raises two one-cycle pulses: a remap request carrying the code 2 and a software reset request. It then stays silent. Any failure sends the block back to offering the start byte.

Top module: `ser_boot_engine`

## Requirements
- R1: Out of reset, and after every failed session, the block offers the start byte 0x02 with `tx_valid` high. A byte is sent in a cycle where both `tx_valid` and `tx_ready` are high. `tx_valid` and `tx_data` stay unchanged while `tx_ready` is low.
- R2: Once the start byte is sent, the next three received bytes are taken as the header, in this order: marker, length bits 7:0, length bits 15:8.
- R3: The block answers the header with 0x06 when the marker equals 0x01 and the length is non-zero. In every other case it answers 0x15 and then goes back to offering 0x02.
- R4: Payload byte k is written into bits 8*(k mod 4)+7 down to 8*(k mod 4) of the word at address 0x07FC0000 + 4*(k div 4). Every session starts again at the base address.
- R5: When the length is not a multiple of 4, the last word is still written, and its unused upper bytes are zero.
- R6: After the last payload byte, the block offers one byte on tx. That byte is the XOR of all payload bytes, starting from 0x00.
- R7: If the host's reply to the checksum is 0x06, then one cycle later `remap_req` and `swrst_req` are high for exactly one cycle, with `remap_sel` = 2. After that the block sends nothing more and writes nothing more.
- R8: Any other reply to the checksum sends the block back to offering 0x02, with no remap or reset pulse.
- R9: Bytes received while the block is offering a byte are ignored.
- R10: A RAM write happens in the clock cycle right after the byte that fills its word, or right after the last payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | UART core accepts the offered byte |
| tx_valid | output | 1 | A byte is offered for sending |
| tx_data | output | 8 | Offered byte |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | 32 | RAM byte address of the word |
| ram_wdata | output | 32 | RAM word data |
| remap_req | output | 1 | One-cycle remap request |
| remap_sel | output | 2 | Remap code, 2 while `remap_req` is high |
| swrst_req | output | 1 | One-cycle software reset request |

## Verification
The last payload byte has two effects that land in the same clock cycle. It flushes the final, possibly partial, word to RAM, and the finished checksum appears on tx. The bench provokes this collision with payload lengths of 5 and 8, so the final word is partial in one case and full in the other.

In the cycle of that last write, the bench's reference checks the RAM address and data and the write timing. It also checks that tx already offers the expected checksum in that same cycle. The other collision case is a received byte arriving while the block is offering a byte. The bench provokes it with stray bytes, and judges it by the block's later behaviour: the session still completes correctly.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int LEN_W = 16;

    localparam logic [7:0] C_STX  = 8'h02;
    localparam logic [7:0] C_SOH  = 8'h01;
    localparam logic [7:0] C_ACK  = 8'h06;
    localparam logic [7:0] C_NACK = 8'h15;
    localparam logic [1:0] C_REMAP_SEL = 2'h2;

    typedef enum logic [3:0] {
        ST_STX, ST_MARK, ST_LLO, ST_LHI, ST_RPLY,
        ST_LOAD, ST_SUM, ST_FIN, ST_DONE
    } boot_state_t;

    typedef struct packed {
        logic       vld;
        logic       last;
        logic [7:0] data;
    } pay_beat_t;

    function automatic logic hdr_bad(input logic [7:0] mark, input logic [LEN_W-1:0] len);
        return (mark != C_SOH) || (len == '0);
    endfunction

endpackage

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        tx_ready,
    input  logic [7:0]  chk_in,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output pay_beat_t   beat,
    output logic        sess_clr,
    output logic        load_phase,
    output logic        sum_phase,
    output logic        remap_req,
    output logic        swrst_req
);
    boot_state_t            st;
    logic [7:0]             mark_q;
    logic [7:0]             len_lo;
    logic                   hdr_err;
    logic [LEN_W-1:0]       rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_STX;
            mark_q    <= '0;
            len_lo    <= '0;
            hdr_err   <= 1'b0;
            rem       <= '0;
            remap_req <= 1'b0;
            swrst_req <= 1'b0;
        end else begin
            remap_req <= 1'b0;
            swrst_req <= 1'b0;
            case (st)
                ST_STX:  if (tx_ready) st <= ST_MARK;
                ST_MARK: if (rx_valid) begin mark_q <= rx_data; st <= ST_LLO; end
                ST_LLO:  if (rx_valid) begin len_lo <= rx_data; st <= ST_LHI; end
                ST_LHI:  if (rx_valid) begin
                    rem     <= {rx_data, len_lo};
                    hdr_err <= hdr_bad(mark_q, {rx_data, len_lo});
                    st      <= ST_RPLY;
                end
                ST_RPLY: if (tx_ready) st <= hdr_err ? ST_STX : ST_LOAD;
                ST_LOAD: if (rx_valid) begin
                    rem <= rem - 1'b1;
                    if (rem == 1) st <= ST_SUM;
                end
                ST_SUM:  if (tx_ready) st <= ST_FIN;
                ST_FIN:  if (rx_valid) begin
                    if (rx_data == C_ACK) begin
                        st        <= ST_DONE;
                        remap_req <= 1'b1;
                        swrst_req <= 1'b1;
                    end else begin
                        st <= ST_STX;
                    end
                end
                ST_DONE: st <= ST_DONE;
                default: st <= ST_STX;
            endcase
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        case (st)
            ST_STX:  begin tx_valid = 1'b1; tx_data = C_STX; end
            ST_RPLY: begin tx_valid = 1'b1; tx_data = hdr_err ? C_NACK : C_ACK; end
            ST_SUM:  begin tx_valid = 1'b1; tx_data = chk_in; end
            default: ;
        endcase
    end

    assign beat.vld   = (st == ST_LOAD) && rx_valid;
    assign beat.last  = (rem == 1);
    assign beat.data  = rx_data;
    assign sess_clr   = (st == ST_STX);
    assign load_phase = (st == ST_LOAD);
    assign sum_phase  = (st == ST_SUM);

    // R1
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        remap_req |=> !remap_req && !tx_valid);

endmodule

// File: rtl/boot_xsum.sv
module boot_xsum (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       vld,
    input  logic [7:0] data,
    output logic [7:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clr) sum <= 8'h00;
        else if (vld)   sum <= sum ^ data;
    end
endmodule

// File: rtl/boot_wpack.sv
module boot_wpack
    import boot_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          WORD_BYTES = 4,
    parameter logic [31:0] BASE_ADDR  = 32'h07FC_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  pay_beat_t               beat,
    output logic                    ram_we,
    output logic [ADDR_W-1:0]       ram_addr,
    output logic [8*WORD_BYTES-1:0] ram_wdata
);
    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam int WIDX_W = LEN_W - LANE_W + 1;
    localparam int DATA_W = 8 * WORD_BYTES;

    logic [WORD_BYTES-1:0][7:0] lane_q;
    logic [LANE_W-1:0]          idx;
    logic [WIDX_W-1:0]          widx;
    logic [DATA_W-1:0]          comp;
    logic                       flush;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign comp[8*g +: 8] = (LANE_W'(g) < idx)  ? lane_q[g] :
                                (LANE_W'(g) == idx) ? beat.data : 8'h00;
    end

    assign flush = beat.vld && (beat.last || idx == LANE_W'(WORD_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q    <= '0;
            idx       <= '0;
            widx      <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= 1'b0;
            if (clr) begin
                idx  <= '0;
                widx <= '0;
            end else if (beat.vld) begin
                for (int i = 0; i < WORD_BYTES; i++)
                    if (LANE_W'(i) == idx) lane_q[i] <= beat.data;
                if (flush) begin
                    ram_we    <= 1'b1;
                    ram_wdata <= comp;
                    ram_addr  <= ADDR_W'(BASE_ADDR) + (ADDR_W'(widx) << LANE_W);
                    widx      <= widx + 1'b1;
                    idx       <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ser_boot_engine.sv
module ser_boot_engine
    import boot_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          WORD_BYTES = 4,
    parameter logic [31:0] BASE_ADDR  = 32'h07FC_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    input  logic                    tx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    output logic                    ram_we,
    output logic [ADDR_W-1:0]       ram_addr,
    output logic [8*WORD_BYTES-1:0] ram_wdata,
    output logic                    remap_req,
    output logic [1:0]              remap_sel,
    output logic                    swrst_req
);
    pay_beat_t  beat;
    logic       sess_clr;
    logic       load_phase;
    logic       sum_phase;
    logic [7:0] chk;

    boot_fsm u_fsm (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .chk_in(chk), .tx_valid(tx_valid), .tx_data(tx_data),
        .beat(beat), .sess_clr(sess_clr), .load_phase(load_phase),
        .sum_phase(sum_phase), .remap_req(remap_req), .swrst_req(swrst_req)
    );

    boot_xsum u_xsum (
        .clk(clk), .rst(rst), .clr(sess_clr), .vld(beat.vld),
        .data(beat.data), .sum(chk)
    );

    boot_wpack #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BASE_ADDR(BASE_ADDR)) u_pack (
        .clk(clk), .rst(rst), .clr(sess_clr), .beat(beat),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    assign remap_sel = remap_req ? C_REMAP_SEL : 2'h0;

    // R5
    flush_with_sum_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sum_phase) |-> ram_we);

    // R10
    write_in_load_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(load_phase));

endmodule

// File: tb/ser_boot_engine_bench.sv
module ser_boot_engine_bench;
    localparam logic [31:0] BASE = 32'h07FC_0000;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        int          cyc;
        bit          last;
        logic [7:0]  sum;
    } wr_exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        rx_valid = 0;
    logic [7:0]  rx_data = 0;
    logic        tx_ready = 0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        ram_we;
    logic [31:0] ram_addr;
    logic [31:0] ram_wdata;
    logic        remap_req;
    logic [1:0]  remap_sel;
    logic        swrst_req;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int remap_cnt = 0;
    bit finished = 0;
    wr_exp_t wq[$];
    logic [7:0] exp_sum;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ser_boot_engine u_ser_boot_engine (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .remap_req(remap_req), .remap_sel(remap_sel), .swrst_req(swrst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference monitor, compared every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we) begin
                if (wq.size() == 0) begin
                    chk("R4 unexpected write", ram_addr, 32'hxxxx_xxxx);
                end else begin
                    wr_exp_t e;
                    e = wq.pop_front();
                    chk("R4 write address", ram_addr, e.addr);
                    chk("R4/R5 write data", ram_wdata, e.data);
                    chk("R10 write cycle", cyc, e.cyc);
                    if (e.last) begin
                        chk("R6 checksum offered with last write", {tx_valid, tx_data}, {1'b1, e.sum});
                    end
                end
            end
            if (remap_req) begin
                remap_cnt++;
                chk("R7 remap code and reset pulse", {remap_sel, swrst_req}, {2'h2, 1'b1});
            end else if (swrst_req || remap_sel != 0) begin
                chk("R7 lone reset or code", {remap_sel, swrst_req}, 3'b0);
            end
        end
    end

    task automatic send_rx(input logic [7:0] b);
        rx_valid = 1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic get_tx(input string tag, input logic [7:0] exp, input int stall);
        tx_ready = 0;
        repeat (stall) @(negedge clk);
        while (!tx_valid) @(negedge clk);
        chk(tag, tx_data, exp);
        tx_ready = 1;
        @(negedge clk);
        tx_ready = 0;
    endtask

    task automatic send_hdr(input logic [7:0] mark, input logic [15:0] len);
        send_rx(mark);
        send_rx(len[7:0]);
        send_rx(len[15:8]);
    endtask

    task automatic send_payload(input int n, input logic [7:0] seed);
        logic [31:0] w;
        logic [7:0]  s;
        w = 0;
        s = 0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = seed + 8'(k * 37);
            s ^= b;
            w[8*(k%4) +: 8] = b;
            if (k % 4 == 3 || k == n - 1) begin
                wr_exp_t e;
                e.addr = BASE + 32'(4 * (k / 4));
                e.data = w;
                e.cyc  = cyc + 1;
                e.last = (k == n - 1);
                e.sum  = s;
                wq.push_back(e);
                w = 0;
            end
            send_rx(b);
        end
        exp_sum = s;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 reset: no write", {31'b0, ram_we}, 0);
        chk("R7 reset: no remap", {remap_req, swrst_req}, 2'b0);
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 start byte offered", {tx_valid, tx_data}, {1'b1, 8'h02});

        // R9: stray byte while start byte waits, then held output
        send_rx(8'h01);
        get_tx("R1 R9 start byte held", 8'h02, 3);

        // R3: bad marker
        send_hdr(8'h55, 16'd4);
        get_tx("R3 reject bad marker", 8'h15, 1);
        get_tx("R3 restart after reject", 8'h02, 0);

        // R3: zero length
        send_hdr(8'h01, 16'd0);
        get_tx("R3 reject zero length", 8'h15, 2);
        get_tx("R3 restart after zero length", 8'h02, 0);

        // length 5, wrong final reply (R2 length bytes little-endian)
        send_hdr(8'h01, 16'd5);
        get_tx("R2 R3 accept header", 8'h06, 0);
        send_payload(5, 8'hA1);
        send_rx(8'h06);          // R9: stray byte while checksum waits
        get_tx("R6 checksum len5", exp_sum, 2);
        send_rx(8'h55);
        get_tx("R8 restart after bad final reply", 8'h02, 1);
        chk("R8 no remap pulse", remap_cnt, 0);

        // length 8, accepted
        send_hdr(8'h01, 16'd8);
        get_tx("R2 accept header len8", 8'h06, 1);
        send_payload(8, 8'h3C);
        get_tx("R6 checksum len8", exp_sum, 0);
        send_rx(8'h06);
        repeat (6) @(negedge clk);
        chk("R7 single remap pulse", remap_cnt, 1);
        chk("R7 silent after done", {31'b0, tx_valid}, 0);
        chk("R4 all writes seen", wq.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule